// File: doc/BRIEF.md
# Deferred Debug Interrupt Controller

This block keeps the debug status of a small processor core and decides when a debug interrupt is requested. Every cycle it takes eight single-cycle event strobes from the rest of the core: instruction complete, branch taken, exception taken, trap, unconditional, instruction address match, data address match and data value match. It also takes a flag that says whether instruction address range toggling is on. Each strobe sets its own sticky status bit.

If an event arrives while debug interrupts are disabled and that event qualifies under the masking rules, a further sticky "deferred" bit is set next to the event's own bit. Once software enables debug interrupts, a pending deferred bit requests the interrupt at once. The block then saves the address of the instruction after the one whose register write caused the request.

The debug-enable and internal-mode flags are loaded by a register-write strobe. That strobe carries the address of the instruction doing the write. Status bits are cleared by a write-one-to-clear vector. The interrupt handler must clear the deferred bit, or the request stays raised.

Top module: `dbg_imp_ctrl`

## Requirements
- R1: After reset, the status vector, both configuration flags, the interrupt request and the saved address all read 0.
- R2: A strobe on event input bit i (0 instruction complete, 1 branch taken, 2 exception taken, 3 trap, 4 unconditional, 5 instruction address match, 6 data address match, 7 data value match) sets status bit i on the following clock edge, whatever the configuration.
- R3: While the debug-enable flag is 0, a strobe on exception taken, trap, unconditional, data address match or data value match also sets the deferred bit (status bit 8).
- R4: Instruction complete and branch taken set the deferred bit only when the internal-mode flag is 0.
- R5: An instruction address match does not set the deferred bit when range toggling and the internal-mode flag are both 1; otherwise it qualifies like R3.
- R6: While the debug-enable flag is 1, no event sets the deferred bit.
- R7: The interrupt request is 1 exactly when the debug-enable flag is 1 and either the deferred bit is set, or the internal-mode flag is 1 and any event status bit is set.
- R8: When a configuration write makes the interrupt request rise, the saved address becomes that write's instruction address plus 4. This holds whether the write set the enable flag or the internal-mode flag.
- R9: Each 1 in the clear vector clears the matching status bit. An event that sets the same bit in the same cycle wins, and the bit stays set.
- R10: The deferred bit stays set, and the request stays raised, until software clears bit 8. Clearing only the event bits keeps it.
- R11: A configuration write loads both flags, and they show on their outputs from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Per-cycle debug event strobes |
| iac_toggle_i | input | 1 | Instruction address range toggling is on |
| cfg_we_i | input | 1 | Write strobe for the configuration flags |
| cfg_de_i | input | 1 | New debug-enable value |
| cfg_idm_i | input | 1 | New internal-mode value |
| cfg_pc_i | input | AW | Address of the writing instruction |
| sts_clr_i | input | 9 | Write-one-to-clear vector for the status bits |
| de_o | output | 1 | Debug-enable flag |
| idm_o | output | 1 | Internal-mode flag |
| sts_o | output | 9 | Status bits; bit 8 is the deferred bit |
| irq_o | output | 1 | Debug interrupt request |
| saved_addr_o | output | AW | Saved next-instruction address |

## Verification
The bench drives each masking rule across both mode settings. A design that ignored the internal-mode flag would record a deferred event for instruction complete, and one that missed the range-toggle case would do the same for an address match. Deferred requests are raised by setting the enable flag in one scenario and by setting the internal-mode flag in another. A saved address taken from the event, or from a write that did not raise the request, would not equal the write address plus 4. Clearing bits on their own or in the same cycle as a new event shows up a clear that wins over a set, and a deferred bit that is dropped when only the event bits are cleared.

// File: rtl/dbg_imp_pkg.sv
package dbg_imp_pkg;
   localparam int N_EVT   = 8;
   localparam int IMP_BIT = N_EVT;
   localparam int STS_W   = N_EVT + 1;

   typedef enum int {
      EV_IC   = 0,
      EV_BT   = 1,
      EV_EXC  = 2,
      EV_TRAP = 3,
      EV_UNC  = 4,
      EV_IAC  = 5,
      EV_DAC  = 6,
      EV_DVC  = 7
   } ev_e;

   function automatic logic irq_cond(input logic de, input logic idm,
                                     input logic [STS_W-1:0] sts);
      return de & (sts[IMP_BIT] | (idm & (|sts[N_EVT-1:0])));
   endfunction
endpackage

// File: rtl/dbg_imp_qual.sv
module dbg_imp_qual
   import dbg_imp_pkg::*;
(
   input  logic [N_EVT-1:0] evt,
   input  logic             de,
   input  logic             idm,
   input  logic             iac_tog,
   output logic             imp_hit
);
   logic [N_EVT-1:0] qual;

   for (genvar g = 0; g < N_EVT; g++) begin : g_q
      if (g == int'(EV_IC) || g == int'(EV_BT)) begin : g_mode
         assign qual[g] = evt[g] & ~idm;
      end else if (g == int'(EV_IAC)) begin : g_tog
         assign qual[g] = evt[g] & ~(iac_tog & idm);
      end else begin : g_always
         assign qual[g] = evt[g];
      end
   end

   assign imp_hit = ~de & (|qual);
endmodule

// File: rtl/dbg_imp_status.sv
module dbg_imp_status #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] sts,
   output logic [W-1:0] sts_nxt
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      assign sts_nxt[b] = set[b] | (sts[b] & ~clr[b]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sts[b] <= 1'b0;
         else        sts[b] <= sts_nxt[b];
      end
   end
endmodule

// File: rtl/dbg_imp_irq.sv
module dbg_imp_irq
   import dbg_imp_pkg::*;
#(
   parameter int AW      = 32,
   parameter int PC_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             de,
   input  logic             idm,
   input  logic             de_nxt,
   input  logic             idm_nxt,
   input  logic [STS_W-1:0] sts,
   input  logic [STS_W-1:0] sts_nxt,
   input  logic             cfg_we,
   input  logic [AW-1:0]    cfg_pc,
   output logic             irq,
   output logic [AW-1:0]    saved_addr
);
   localparam logic [AW-1:0] STEP = AW'(PC_STEP);

   logic irq_nxt;

   assign irq     = irq_cond(de, idm, sts);
   assign irq_nxt = irq_cond(de_nxt, idm_nxt, sts_nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          saved_addr <= '0;
      else if (cfg_we && !irq && irq_nxt)  saved_addr <= cfg_pc + STEP;
   end
endmodule

// File: rtl/dbg_imp_ctrl.sv
module dbg_imp_ctrl
   import dbg_imp_pkg::*;
#(
   parameter int AW      = 32,
   parameter int PC_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic             iac_toggle_i,
   input  logic             cfg_we_i,
   input  logic             cfg_de_i,
   input  logic             cfg_idm_i,
   input  logic [AW-1:0]    cfg_pc_i,
   input  logic [STS_W-1:0] sts_clr_i,
   output logic             de_o,
   output logic             idm_o,
   output logic [STS_W-1:0] sts_o,
   output logic             irq_o,
   output logic [AW-1:0]    saved_addr_o
);
   if (AW < 8) begin : g_bad_aw
      $error("dbg_imp_ctrl: AW must be at least 8");
   end
   if (PC_STEP < 1 || PC_STEP > 16) begin : g_bad_step
      $error("dbg_imp_ctrl: PC_STEP out of range");
   end

   logic             de_q, idm_q, de_nxt, idm_nxt, imp_hit;
   logic [STS_W-1:0] set_vec, sts_nxt;

   assign de_nxt  = cfg_we_i ? cfg_de_i  : de_q;
   assign idm_nxt = cfg_we_i ? cfg_idm_i : idm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         de_q  <= 1'b0;
         idm_q <= 1'b0;
      end else begin
         de_q  <= de_nxt;
         idm_q <= idm_nxt;
      end
   end

   dbg_imp_qual u_qual (
      .evt     (evt_i),
      .de      (de_q),
      .idm     (idm_q),
      .iac_tog (iac_toggle_i),
      .imp_hit (imp_hit)
   );

   assign set_vec = {imp_hit, evt_i};

   dbg_imp_status #(.W(STS_W)) u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (set_vec),
      .clr     (sts_clr_i),
      .sts     (sts_o),
      .sts_nxt (sts_nxt)
   );

   dbg_imp_irq #(.AW(AW), .PC_STEP(PC_STEP)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .de         (de_q),
      .idm        (idm_q),
      .de_nxt     (de_nxt),
      .idm_nxt    (idm_nxt),
      .sts        (sts_o),
      .sts_nxt    (sts_nxt),
      .cfg_we     (cfg_we_i),
      .cfg_pc     (cfg_pc_i),
      .irq        (irq_o),
      .saved_addr (saved_addr_o)
   );

   assign de_o  = de_q;
   assign idm_o = idm_q;
endmodule

// File: rtl/dbg_imp_ctrl_chk.sv
module dbg_imp_ctrl_chk #(
   parameter int AW      = 32,
   parameter int PC_STEP = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    evt_i,
   input logic          cfg_we_i,
   input logic [AW-1:0] cfg_pc_i,
   input logic [8:0]    sts_clr_i,
   input logic          de_o,
   input logic          idm_o,
   input logic [8:0]    sts_o,
   input logic          irq_o,
   input logic [AW-1:0] saved_addr_o
);
   // R3
   exc_defers_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[2] && !de_o) |=> sts_o[8]);

   // R4
   ic_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i == 8'h01 && idm_o && !de_o && !sts_o[8]) |=> !sts_o[8]);

   // R6
   enabled_no_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (de_o && !sts_o[8]) |=> !sts_o[8]);

   // R7
   irq_needs_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> de_o);

   // R8
   saved_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && !irq_o) ##1 irq_o |-> saved_addr_o == $past(cfg_pc_i) + AW'(PC_STEP));

   // R9
   clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr_i[2] && !evt_i[2]) |=> !sts_o[2]);

   // R10
   defer_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_o[8] && !sts_clr_i[8]) |=> sts_o[8]);
endmodule

bind dbg_imp_ctrl dbg_imp_ctrl_chk #(.AW(AW), .PC_STEP(PC_STEP)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .evt_i        (evt_i),
   .cfg_we_i     (cfg_we_i),
   .cfg_pc_i     (cfg_pc_i),
   .sts_clr_i    (sts_clr_i),
   .de_o         (de_o),
   .idm_o        (idm_o),
   .sts_o        (sts_o),
   .irq_o        (irq_o),
   .saved_addr_o (saved_addr_o)
);

// File: tb/dbg_imp_ctrl_bench.sv
module dbg_imp_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt_i = '0;
   logic        iac_toggle_i = 1'b0;
   logic        cfg_we_i = 1'b0;
   logic        cfg_de_i = 1'b0;
   logic        cfg_idm_i = 1'b0;
   logic [31:0] cfg_pc_i = '0;
   logic [8:0]  sts_clr_i = '0;
   logic        de_o, idm_o, irq_o;
   logic [8:0]  sts_o;
   logic [31:0] saved_addr_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dbg_imp_ctrl u_dbg_imp_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .iac_toggle_i(iac_toggle_i),
      .cfg_we_i(cfg_we_i), .cfg_de_i(cfg_de_i), .cfg_idm_i(cfg_idm_i),
      .cfg_pc_i(cfg_pc_i), .sts_clr_i(sts_clr_i), .de_o(de_o), .idm_o(idm_o),
      .sts_o(sts_o), .irq_o(irq_o), .saved_addr_o(saved_addr_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_cfg(input logic de, input logic idm, input logic [31:0] pc);
      cfg_we_i = 1'b1; cfg_de_i = de; cfg_idm_i = idm; cfg_pc_i = pc;
      cycle();
      cfg_we_i = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] ev, input logic [8:0] clr);
      evt_i = ev; sts_clr_i = clr;
      cycle();
      evt_i = '0; sts_clr_i = '0;
   endtask

   task automatic t_reset();
      check("R1 sts", 32'(sts_o), 0);
      check("R1 irq", 32'(irq_o), 0);
      check("R1 flags", {30'd0, de_o, idm_o}, 0);
      check("R1 saved", saved_addr_o, 0);
   endtask

   task automatic t_record();
      pulse(8'h04, '0);
      check("R2 R3 exc", 32'(sts_o), 32'h104);
      pulse('0, 9'h1FF);
      check("R9 clear all", 32'(sts_o), 0);
      pulse(8'h80, '0);
      check("R3 dvc", 32'(sts_o), 32'h180);
      pulse('0, 9'h1FF);
   endtask

   task automatic t_ic_mask();
      wr_cfg(1'b0, 1'b1, 32'h0);
      check("R11 flags", {30'd0, de_o, idm_o}, 32'h1);
      pulse(8'h01, '0);
      check("R4 ic masked", 32'(sts_o), 32'h001);
      pulse(8'h02, 9'h1FF);
      check("R4 bt masked", 32'(sts_o), 32'h002);
      wr_cfg(1'b0, 1'b0, 32'h0);
      pulse(8'h01, 9'h1FF);
      check("R4 ic qualifies", 32'(sts_o), 32'h101);
      pulse('0, 9'h1FF);
   endtask

   task automatic t_iac();
      wr_cfg(1'b0, 1'b1, 32'h0);
      iac_toggle_i = 1'b1;
      pulse(8'h20, '0);
      check("R5 iac masked", 32'(sts_o), 32'h020);
      iac_toggle_i = 1'b0;
      pulse(8'h20, 9'h1FF);
      check("R5 iac qualifies", 32'(sts_o), 32'h120);
      pulse('0, 9'h1FF);
   endtask

   task automatic t_enabled();
      wr_cfg(1'b1, 1'b0, 32'h0);
      check("R11 de set", {30'd0, de_o, idm_o}, 32'h2);
      pulse(8'h40, '0);
      check("R6 no defer", 32'(sts_o), 32'h040);
      check("R7 no irq without mode", 32'(irq_o), 0);
      pulse('0, 9'h1FF);
      wr_cfg(1'b1, 1'b1, 32'h0);
      pulse(8'h01, '0);
      check("R7 precise irq", 32'(irq_o), 1);
      pulse('0, 9'h1FF);
      check("R7 irq drops", 32'(irq_o), 0);
   endtask

   task automatic t_deferred();
      wr_cfg(1'b0, 1'b0, 32'h0);
      pulse(8'h08, '0);
      check("R3 trap", 32'(sts_o), 32'h108);
      check("R7 no irq while disabled", 32'(irq_o), 0);
      wr_cfg(1'b1, 1'b0, 32'h100);
      check("R7 deferred irq", 32'(irq_o), 1);
      check("R8 saved by de", saved_addr_o, 32'h104);
      cycle();
      check("R10 irq holds", 32'(irq_o), 1);
      pulse('0, 9'h008);
      check("R10 event cleared", 32'(sts_o), 32'h100);
      check("R10 irq still", 32'(irq_o), 1);
      pulse('0, 9'h100);
      check("R10 cleared", 32'(irq_o), 0);
   endtask

   task automatic t_idm_enable();
      pulse(8'h10, '0);
      check("R6 unc enabled", 32'(sts_o), 32'h010);
      check("R7 idle", 32'(irq_o), 0);
      wr_cfg(1'b1, 1'b1, 32'h200);
      check("R7 mode irq", 32'(irq_o), 1);
      check("R8 saved by mode", saved_addr_o, 32'h204);
      pulse('0, 9'h1FF);
   endtask

   task automatic t_set_wins();
      wr_cfg(1'b0, 1'b0, 32'h300);
      check("R8 no save without irq", saved_addr_o, 32'h204);
      pulse(8'h80, 9'h180);
      check("R9 set wins", 32'(sts_o), 32'h180);
      pulse('0, 9'h1FF);
      check("R9 cleared", 32'(sts_o), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_record();
      t_ic_mask();
      t_iac();
      t_enabled();
      t_deferred();
      t_idm_enable();
      t_set_wins();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule